// File: doc/BRIEF.md
# Multiframe Phase Aligner

This block keeps a free-running multiframe counter in the link clock domain. It brings the counter's phase into line with an external alignment pulse. The pulse is first captured by a register. Its rising edge is detected, and after a fixed two-cycle delay the counter is forced back to zero. From then on, every multiframe boundary of the link falls at a known, repeatable time relative to the pulse. This is the basis for deterministic latency across power cycles.

The block reports the following:

- the current count;
- a one-cycle strobe on every boundary;
- a lock flag, set by the first alignment;
- a one-cycle flag when a later pulse actually moves the phase.

It also drives the active-low synchronisation request. The request is released only on a boundary, once the counter is locked and the local receiver says it is ready. If the receiver withdraws readiness, the request is asserted again. A pulse that arrives in step with the running phase leaves the count sequence undisturbed.

Top module: `mf_phase_aligner`

## Requirements
- R1: While `rst_n` is low, and on the clock edge where it is sampled low, `mf_count` is 0, and `mf_boundary`, `phase_locked`, `phase_shift` and `sync_n` are all 0.
- R2: Without an alignment event, `mf_count` advances by one on every clock edge. It wraps from `MF_LEN-1` (7 by default) to 0.
- R3: After the first clock edge following reset release, `mf_boundary` is 1 in exactly those cycles in which `mf_count` is 0.
- R4: Suppose `sysref_in` is sampled high at edge e after being sampled low at edge e-1. Then `mf_count` reads 0 after edge e+2, whatever its previous value.
- R5: Only a low-to-high change of the sampled `sysref_in` realigns. A pulse held high for many cycles realigns once, and the counter then runs freely while the pulse stays high.
- R6: A pulse whose realignment lands where the count would wrap to 0 anyway leaves the count sequence unchanged and keeps `phase_shift` at 0.
- R7: When already locked, a pulse whose realignment lands anywhere other than the natural wrap makes `phase_shift` 1 for exactly the one cycle in which the forced 0 appears.
- R8: `phase_locked` becomes 1 together with the first forced 0 and stays 1 until reset. The first alignment does not raise `phase_shift`.
- R9: `sync_n` changes from 0 to 1 only in a cycle in which `mf_count` becomes 0. This requires that `phase_locked` was already 1 before that edge and that `link_ready` was sampled 1. Once released, it stays 1 while `link_ready` stays 1.
- R10: `link_ready` sampled 0 at an edge drives `sync_n` to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sysref_in | input | 1 | Alignment pulse, synchronous to `clk` |
| link_ready | input | 1 | Receiver ready to leave the synchronisation request |
| mf_count | output | $clog2(MF_LEN) | Current multiframe count |
| mf_boundary | output | 1 | High in each cycle the count is 0 |
| phase_locked | output | 1 | Set by the first alignment |
| phase_shift | output | 1 | One-cycle flag: a later pulse moved the phase |
| sync_n | output | 1 | Active-low synchronisation request |

## Verification
The counter is first left to run with no pulse, so that the plain wrap can be told apart from a forced zero. The first pulse is then issued with readiness low. This shows that locking alone does not release the request, and that the first alignment raises no shift flag. A pulse held high for twenty cycles separates edge detection from level sensitivity. Readiness is dropped and restored to separate immediate re-assertion from boundary-timed release. Two directed pulses are then timed so that one lands exactly on the natural wrap and one lands mid-frame. This distinguishes a harmless in-phase pulse from a real phase move, and it pins the two-cycle delay to the exact cycle.

// File: rtl/mfa_pkg.sv
// Package: shared constants and types for the multiframe phase aligner.
// Assumes: nothing beyond IEEE 1800-2017.
package mfa_pkg;

    // Default multiframe length in link clocks.
    localparam int unsigned MFA_DEF_MF_LEN = 8;

    // Default edges from a sampled rising pulse to the forced zero.
    localparam int unsigned MFA_DEF_DELAY = 2;

    // States of the synchronisation-request release logic.
    typedef enum logic [1:0] {
        SYNC_HOLD  = 2'b00,   // request asserted, receiver not ready
        SYNC_ARMED = 2'b01,   // ready, waiting for lock and a boundary
        SYNC_RUN   = 2'b10    // request released
    } sync_state_t;

endpackage

// File: rtl/mfa_sysref_capture.sv
// mfa_sysref_capture: registers the alignment pulse, detects its rising edge
// and delays that event so the load strobe arrives ALIGN_DELAY edges after
// the pulse was sampled high (the last stage is the load itself).
// Assumes: sysref_in is synchronous to clk; ALIGN_DELAY >= 2.
module mfa_sysref_capture #(
    parameter int unsigned ALIGN_DELAY = mfa_pkg::MFA_DEF_DELAY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_in,
    output logic load_o
);

    localparam int unsigned STAGES = ALIGN_DELAY - 1;

    logic sref_q;
    logic sref_q2;
    logic rise;
    logic [STAGES-1:0] pipe;

    // Capture the pulse and keep one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sref_q  <= 1'b0;
            sref_q2 <= 1'b0;
        end else begin
            sref_q  <= sysref_in;
            sref_q2 <= sref_q;
        end
    end

    // Rising edge of the registered pulse.
    always_comb begin
        rise = sref_q & ~sref_q2;
    end

    generate
        if (STAGES == 1) begin : g_single
            // Single delay stage feeding the counter load.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= rise;
            end
        end else begin : g_multi
            // Shift chain for longer deterministic delays.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], rise};
            end
        end
    endgenerate

    assign load_o = pipe[STAGES-1];

endmodule

// File: rtl/mfa_mf_counter.sv
// mfa_mf_counter: free-running modulo-MF_LEN counter with a synchronous load
// to zero, a registered boundary strobe, a lock flag and a phase-move flag.
// Assumes: load_i is a single-cycle strobe; MF_LEN >= 2.
module mfa_mf_counter #(
    parameter int unsigned MF_LEN = mfa_pkg::MFA_DEF_MF_LEN,
    localparam int unsigned CNT_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             next_zero_o,
    output logic             boundary_o,
    output logic             locked_o,
    output logic             shift_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_last;

    // Next count: forced zero on load, otherwise increment with wrap.
    always_comb begin
        at_last = (cnt_q == LAST);
        if (load_i || at_last) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    // Count, boundary strobe, lock and phase-move flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            boundary_o <= 1'b0;
            locked_o   <= 1'b0;
            shift_o    <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            boundary_o <= (cnt_d == '0);
            locked_o   <= locked_o | load_i;
            shift_o    <= load_i & locked_o & ~at_last;
        end
    end

    assign cnt_o       = cnt_q;
    assign next_zero_o = (cnt_d == '0);

endmodule

// File: rtl/mfa_sync_release.sv
// mfa_sync_release: drives the active-low synchronisation request. Released
// only at a boundary after lock while ready; re-asserted when ready drops.
// Assumes: next_zero_i marks the edge at which the count becomes zero.
module mfa_sync_release (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ready,
    input  logic locked_i,
    input  logic next_zero_i,
    output logic sync_n_o
);

    import mfa_pkg::*;

    sync_state_t state_q;
    sync_state_t state_d;

    // Next-state selection for the release sequence.
    always_comb begin
        if (!link_ready)                   state_d = SYNC_HOLD;
        else if (state_q == SYNC_RUN)      state_d = SYNC_RUN;
        else if (locked_i && next_zero_i)  state_d = SYNC_RUN;
        else                               state_d = SYNC_ARMED;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SYNC_HOLD;
        else        state_q <= state_d;
    end

    assign sync_n_o = (state_q == SYNC_RUN);

endmodule

// File: rtl/mf_phase_aligner.sv
// mf_phase_aligner: top level. Captures the alignment pulse, realigns the
// multiframe counter a fixed delay later and releases the synchronisation
// request on a boundary.
// Assumes: single clock domain, synchronous active-low reset.
module mf_phase_aligner #(
    parameter int unsigned MF_LEN      = mfa_pkg::MFA_DEF_MF_LEN,
    parameter int unsigned ALIGN_DELAY = mfa_pkg::MFA_DEF_DELAY,
    localparam int unsigned CNT_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sysref_in,
    input  logic             link_ready,
    output logic [CNT_W-1:0] mf_count,
    output logic             mf_boundary,
    output logic             phase_locked,
    output logic             phase_shift,
    output logic             sync_n
);

    logic load;
    logic next_zero;

    mfa_sysref_capture #(.ALIGN_DELAY(ALIGN_DELAY)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysref_in (sysref_in),
        .load_o    (load)
    );

    mfa_mf_counter #(.MF_LEN(MF_LEN)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .cnt_o       (mf_count),
        .next_zero_o (next_zero),
        .boundary_o  (mf_boundary),
        .locked_o    (phase_locked),
        .shift_o     (phase_shift)
    );

    mfa_sync_release u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_ready  (link_ready),
        .locked_i    (phase_locked),
        .next_zero_i (next_zero),
        .sync_n_o    (sync_n)
    );

endmodule

// File: rtl/mf_phase_aligner_checker.sv
// mf_phase_aligner_checker: temporal properties on the top-level ports.
// Assumes: attached through the bind below.
module mf_phase_aligner_checker #(
    parameter int unsigned MF_LEN      = 8,
    parameter int unsigned ALIGN_DELAY = 2,
    localparam int unsigned CNT_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sysref_in,
    input logic             link_ready,
    input logic [CNT_W-1:0] mf_count,
    input logic             mf_boundary,
    input logic             phase_locked,
    input logic             phase_shift,
    input logic             sync_n
);

    // R2: a nonzero count is always its predecessor plus one.
    p_increment_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mf_count != '0) |-> mf_count == CNT_W'($past(mf_count) + 1'b1));

    // R3: boundary strobe tracks a zero count.
    p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mf_boundary == (mf_count == '0)));

    generate
        if (ALIGN_DELAY == 2) begin : g_align
            // R4: a sampled rising pulse forces zero two edges later.
            p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 4) && $past(rst_n, 3) && $past(sysref_in, 3) && !$past(sysref_in, 4))
                |-> mf_count == '0);
        end
    endgenerate

    // R7: the phase-move flag only appears with a forced zero.
    p_shift_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_shift |-> (mf_count == '0 && phase_locked));

    // R8: lock is sticky.
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_locked)) |-> phase_locked);

    // R9: release happens only on a boundary after lock.
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(sync_n)) |-> (mf_count == '0 && $past(phase_locked)));

    // R10: losing readiness re-asserts the request.
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(link_ready)) |-> !sync_n);

endmodule

bind mf_phase_aligner mf_phase_aligner_checker #(
    .MF_LEN      (MF_LEN),
    .ALIGN_DELAY (ALIGN_DELAY)
) i_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sysref_in    (sysref_in),
    .link_ready   (link_ready),
    .mf_count     (mf_count),
    .mf_boundary  (mf_boundary),
    .phase_locked (phase_locked),
    .phase_shift  (phase_shift),
    .sync_n       (sync_n)
);

// File: tb/test_mf_phase_aligner.sv
module test_mf_phase_aligner;

    localparam int MF = 8;
    localparam int W  = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sysref_in = 1'b0;
    logic         link_ready = 1'b0;
    logic [W-1:0] mf_count;
    logic         mf_boundary;
    logic         phase_locked;
    logic         phase_shift;
    logic         sync_n;

    int checks = 0;
    int errors = 0;

    // Model state, derived from the requirements.
    logic [3:0] hist = '0;
    int  e_cnt = 0;
    bit  e_bnd = 0, e_lock = 0, e_shift = 0, e_sync = 0;

    always #5 clk = ~clk;

    mf_phase_aligner #(.MF_LEN(MF), .ALIGN_DELAY(2)) i_mf_phase_aligner (
        .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .link_ready(link_ready),
        .mf_count(mf_count), .mf_boundary(mf_boundary), .phase_locked(phase_locked),
        .phase_shift(phase_shift), .sync_n(sync_n)
    );

    // Stimulus table: {sysref, ready, cycles}.
    localparam int NV = 10;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'd12},   // R2 free run, request held
        {1'b1, 1'b0, 8'd1},    // R8 first alignment
        {1'b0, 1'b0, 8'd10},   // R9 locked but not ready
        {1'b0, 1'b1, 8'd12},   // R9 release on boundary
        {1'b1, 1'b1, 8'd20},   // R5 held-high pulse
        {1'b0, 1'b1, 8'd9},
        {1'b0, 1'b0, 8'd3},    // R10 readiness dropped
        {1'b0, 1'b1, 8'd10},
        {1'b1, 1'b1, 8'd1},    // R7 realignment
        {1'b0, 1'b1, 8'd5}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(mf_count == W'(e_cnt), "R2/R4 count", int'(mf_count), e_cnt);
        chk(mf_boundary == e_bnd, "R3 boundary", int'(mf_boundary), int'(e_bnd));
        chk(phase_locked == e_lock, "R8 locked", int'(phase_locked), int'(e_lock));
        chk(phase_shift == e_shift, "R6/R7 shift", int'(phase_shift), int'(e_shift));
        chk(sync_n == e_sync, "R9/R10 sync_n", int'(sync_n), int'(e_sync));
    endtask

    task automatic model_reset();
        hist = '0; e_cnt = 0; e_bnd = 0; e_lock = 0; e_shift = 0; e_sync = 0;
    endtask

    // Drive at negedge, update the model after the edge, compare at negedge.
    task automatic step(input logic s, input logic r);
        int  prev;
        bit  pl, ld;
        sysref_in = s;
        link_ready = r;
        @(posedge clk);
        hist = {hist[2:0], s};
        ld = hist[2] & ~hist[3];
        prev = e_cnt;
        pl = e_lock;
        e_cnt = ld ? 0 : ((prev == MF - 1) ? 0 : prev + 1);
        e_shift = ld && pl && (prev != MF - 1);
        e_lock = e_lock | ld;
        e_sync = r && (e_sync || (pl && e_cnt == 0));
        e_bnd = (e_cnt == 0);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        model_reset();
        compare_all();
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < int'(VEC[v][7:0]); c++) step(VEC[v][9], VEC[v][8]);
        end

        // R6: pulse landing exactly on the natural wrap.
        for (int k = 0; k < 3 * MF && int'(mf_count) != MF - 3; k++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk(mf_count == '0, "R6 in-phase count", int'(mf_count), 0);
        chk(phase_shift == 1'b0, "R6 in-phase no shift", int'(phase_shift), 0);

        // R7 and R4: pulse mid-frame moves the phase.
        for (int k = 0; k < 3 * MF && int'(mf_count) != 0; k++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk(mf_count == 3'd1, "R4 before load", int'(mf_count), 1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk(mf_count == '0, "R4 forced zero", int'(mf_count), 0);
        chk(phase_shift == 1'b1, "R7 shift pulse", int'(phase_shift), 1);
        step(1'b0, 1'b1);
        chk(phase_shift == 1'b0, "R7 single cycle", int'(phase_shift), 0);
        chk(sync_n == 1'b1, "R9 stays released", int'(sync_n), 1);

        // R1: reset mid-run.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        compare_all();
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule